// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a single watchdog that software arms through a small 32-bit register port. A control word holds a run bit and a load bit. A 32-bit reload value is written as two 16-bit halves. When software sets the run bit, the counter takes the reload value and counts down once per prescaled tick. One tick comes every 16 system clocks. If software neither retriggers nor stops the counter before the count runs out, the block flags the expiry. It does this on an active-low output pin and on a status bit. Both stay in that state until software either retriggers the counter or stops it.

Every register write must carry the constant 16'h9876 in data bits [31:16] as a key. A write without the key is discarded entirely. This guards the watchdog against stray writes from a runaway program. Reads always return zero in the key half of the word.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `wd_out_n` is 1, `expired` is 0, and the control and both reload registers read as zero.
- R2: A write with `wr_data[31:16] == 16'h9876` updates the addressed register. Address 0 is control, address 1 holds reload bits [15:0] in `wr_data[15:0]`, and address 2 holds reload bits [31:16] in `wr_data[15:0]`.
- R3: A write whose key half differs from 16'h9876 changes no register, no counter state and no output.
- R4: Reads return 16'h0000 in `rd_data[31:16]`. At address 0, bit 0 is run, bit 1 is load and bit 2 is the expiry status. At addresses 1 and 2, bits [15:0] return the matching reload half.
- R5: For a reload value N ≥ 1, expiry takes effect exactly 16·N clock edges after the accepted write that started or retriggered the counter.
- R6: A reload value of zero expires on the first tick, 16 clock edges after the start or retrigger.
- R7: On expiry, `wd_out_n` goes to 0 and `expired` goes to 1. Both hold while the counter runs and no retrigger arrives.
- R8: An accepted control write with load (bit 1) set reloads the count, restarts the prescaler and clears the expiry at that clock edge.
- R9: An accepted control write with run (bit 0) clear stops the count and clears the expiry at that clock edge. A stopped counter never expires.
- R10: The load bit does not stick: it always reads back as 0.
- R11: Setting run when it was clear starts the counter from the reload value with a fresh prescaler, just as a load does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 2 | Register select |
| wr_data | input | 32 | Write data, with the key in bits [31:16] |
| rd_data | output | 32 | Read data for `addr`, combinational |
| wd_out_n | output | 1 | Watchdog output, low when expired |
| expired | output | 1 | Expiry status bit |

## Verification
The embedded properties check several rules on every cycle:
- a rejected key leaves the run bit and the reload value untouched;
- expiry can only begin on a prescaler tick;
- an expired flag never coexists with a stopped counter;
- a start or load always clears the flag on the next cycle;
- a flag held while running, with no retrigger or stop, persists;
- ticks never come back to back.

Some properties need a count of elapsed cycles against a programmed reload value, which the properties do not track. The bench scenarios therefore show:
- the exact expiry edge for several reload values, including zero;
- a retrigger partway through the count that postpones the expiry;
- the register readback layout.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_CTRL   = 2'd0,
        SEL_RLD_LO = 2'd1,
        SEL_RLD_HI = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_LOAD_BIT = 1;
    localparam int CTRL_STAT_BIT = 2;

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic enable,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } presc_t;

    presc_t s_d, s_q;

    assign tick = enable && (s_q.cnt == LAST);

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d.cnt = '0;
        end else if (enable) begin
            s_d.cnt = tick ? '0 : s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R5

endmodule

// File: rtl/wdog_regbank.sv
module wdog_regbank
    import wdog_pkg::*;
#(
    parameter int          DATA_W = 32,
    parameter int          KEY_W  = 16,
    parameter logic [15:0] KEY    = 16'h9876,
    parameter int          CNT_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  expired,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  run,
    output logic                  restart,
    output logic                  halt,
    output logic [CNT_W-1:0]      reload
);
    localparam int HALF = DATA_W - KEY_W;

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] reload;
    } regs_t;

    regs_t s_d, s_q;
    logic  key_ok;
    logic  accept;

    assign key_ok = (wr_data[DATA_W-1 -: KEY_W] == KEY[KEY_W-1:0]);
    assign accept = wr_en && key_ok;

    always_comb begin
        s_d     = s_q;
        restart = 1'b0;
        halt    = 1'b0;
        if (accept) begin
            case (reg_sel_e'(addr))
                SEL_CTRL: begin
                    s_d.run = wr_data[CTRL_RUN_BIT];
                    restart = wr_data[CTRL_LOAD_BIT]
                            | (wr_data[CTRL_RUN_BIT] & ~s_q.run);
                    halt    = ~wr_data[CTRL_RUN_BIT];
                end
                SEL_RLD_LO: s_d.reload[HALF-1:0]     = wr_data[HALF-1:0];
                SEL_RLD_HI: s_d.reload[CNT_W-1:HALF] = wr_data[CNT_W-HALF-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(addr))
            SEL_CTRL: begin
                rd_data[CTRL_RUN_BIT]  = s_q.run;
                rd_data[CTRL_STAT_BIT] = expired;
            end
            SEL_RLD_LO: rd_data[HALF-1:0] = s_q.reload[HALF-1:0];
            SEL_RLD_HI: rd_data[CNT_W-HALF-1:0] = s_q.reload[CNT_W-1:HALF];
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign run    = s_q.run;
    assign reload = s_q.reload;

    AST_KEY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !key_ok) |=> ($stable(s_q.run) && $stable(s_q.reload))); // R3

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             halt,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    output logic             expired
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             expired;
    } cnt_t;

    cnt_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (restart) begin
            s_d.count   = reload;
            s_d.expired = 1'b0;
        end else if (halt || !run) begin
            s_d.expired = 1'b0;
        end else if (tick && !s_q.expired) begin
            if (s_q.count <= CNT_W'(1)) begin
                s_d.count   = '0;
                s_d.expired = 1'b1;
            end else begin
                s_d.count = s_q.count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign expired = s_q.expired;

    AST_EXPIRE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.expired |-> run); // R9
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !s_q.expired); // R8
    AST_EXPIRY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.expired && run && !restart && !halt) |=> s_q.expired); // R7
    AST_EXPIRE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.expired) |-> $past(tick)); // R5

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdog_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          KEY_W     = 16,
    parameter logic [15:0] KEY       = 16'h9876,
    parameter int          TICK_DIV  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  wd_out_n,
    output logic                  expired
);
    localparam int CNT_W = 2 * (DATA_W - KEY_W);

    logic             run;
    logic             restart;
    logic             halt;
    logic             tick;
    logic [CNT_W-1:0] reload;

    wdog_regbank #(
        .DATA_W (DATA_W),
        .KEY_W  (KEY_W),
        .KEY    (KEY),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .expired (expired),
        .rd_data (rd_data),
        .run     (run),
        .restart (restart),
        .halt    (halt),
        .reload  (reload)
    );

    wdog_prescaler #(
        .DIV (TICK_DIV)
    ) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (restart),
        .enable (run),
        .tick   (tick)
    );

    wdog_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .halt    (halt),
        .tick    (tick),
        .reload  (reload),
        .expired (expired)
    );

    assign wd_out_n = ~expired;

endmodule

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;
    // each entry: {addr, write data, expected read-back of same addr}
    localparam logic [65:0] VEC [0:NVEC-1] = '{
        {2'd1, 32'h9876_1234, 32'h0000_1234},  // R2 R4 keyed low half
        {2'd1, 32'h1234_5678, 32'h0000_1234},  // R3 bad key
        {2'd2, 32'h9876_00AB, 32'h0000_00AB},  // R2 keyed high half
        {2'd2, 32'h9877_FFFF, 32'h0000_00AB},  // R3 near-miss key
        {2'd0, 32'h0000_0001, 32'h0000_0000},  // R3 run without key
        {2'd1, 32'h9876_0003, 32'h0000_0003},  // R2
        {2'd2, 32'h9876_0000, 32'h0000_0000}   // R2
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [1:0]  addr = 0;
    logic [31:0] wr_data = 0;
    logic [31:0] rd_data;
    logic        wd_out_n;
    logic        expired;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    keyed_watchdog u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .wd_out_n(wd_out_n),
        .expired(expired)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 wd_out_n", {31'd0, wd_out_n}, 32'd1);
        check("R1 expired", {31'd0, expired}, 32'd0);
        rd(2'd0, r); check("R1 ctrl", r, 32'd0);
        rd(2'd1, r); check("R1 reload lo", r, 32'd0);
        rst_n = 1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][65:64], VEC[i][63:32]);
            rd(VEC[i][65:64], r);
            check("R2/R3/R4 vector", r, VEC[i][31:0]);
        end
        check("R3 no start after keyless run", {31'd0, wd_out_n}, 32'd1);

        // reload = 3 -> expiry 48 edges after start (R5, R11)
        wr(2'd0, 32'h9876_0001);
        wait_cyc(47);
        check("R5 before expiry", {31'd0, wd_out_n}, 32'd1);
        wait_cyc(1);
        check("R5 R7 wd_out_n low", {31'd0, wd_out_n}, 32'd0);
        check("R7 expired set", {31'd0, expired}, 32'd1);
        rd(2'd0, r); check("R4 ctrl run+status", r, 32'h0000_0005);
        wait_cyc(40);
        check("R7 sticky", {31'd0, wd_out_n}, 32'd0);
        wr(2'd0, 32'h1111_0000);
        check("R3 bad-key stop ignored", {31'd0, expired}, 32'd1);

        // R8 retrigger clears at once and restarts full timeout
        wr(2'd0, 32'h9876_0003);
        check("R8 retrigger clears", {31'd0, wd_out_n}, 32'd1);
        rd(2'd0, r); check("R10 load reads 0", r, 32'h0000_0001);
        wait_cyc(47);
        check("R8 full timeout after load", {31'd0, wd_out_n}, 32'd1);
        wait_cyc(1);
        check("R8 expires again", {31'd0, wd_out_n}, 32'd0);

        // R9 stop clears and prevents expiry
        wr(2'd0, 32'h9876_0000);
        check("R9 stop clears", {31'd0, wd_out_n}, 32'd1);
        check("R9 status clear", {31'd0, expired}, 32'd0);
        wait_cyc(100);
        check("R9 stays idle", {31'd0, wd_out_n}, 32'd1);

        // R6 zero reload
        wr(2'd1, 32'h9876_0000);
        wr(2'd0, 32'h9876_0001);
        wait_cyc(15);
        check("R6 before first tick", {31'd0, wd_out_n}, 32'd1);
        wait_cyc(1);
        check("R6 expire on first tick", {31'd0, wd_out_n}, 32'd0);
        wr(2'd0, 32'h9876_0000);

        // R5 with reload 5 and a mid-count retrigger (R8)
        wr(2'd1, 32'h9876_0005);
        wr(2'd0, 32'h9876_0001);
        wait_cyc(40);
        wr(2'd0, 32'h9876_0003);
        wait_cyc(79);
        check("R8 postponed by retrigger", {31'd0, wd_out_n}, 32'd1);
        wait_cyc(1);
        check("R5 reload 5 expiry", {31'd0, wd_out_n}, 32'd0);

        // R4 upper half of high reload register and unused address
        wr(2'd2, 32'h9876_ABCD);
        rd(2'd2, r); check("R4 high half", r, 32'h0000_ABCD);
        rd(2'd3, r); check("R4 unused addr", r, 32'h0000_0000);

        finish_run();
    end
endmodule